// File: doc/BRIEF.md
# Processor Exception State Registers

This block keeps the exception state of a 32-bit processor core in four registers: a status word, a cause word, a saved exception PC and a faulting-address register. The control sequencer raises a one-cycle exception strobe together with a 4-bit reason code, the already-advanced PC and, where relevant, the memory address of the bad reference. The block then records all of this and tells the fetch logic where the handler starts.

The status word carries an 8-bit interrupt mask and a three-level stack of kernel/enable pairs. Taking an exception pushes a fresh "kernel, interrupts off" pair onto that stack. A return-from-exception strobe pops it. Hardware interrupt lines latch into pending flags in the cause word, and those flags combine with the mask and the current enable bit to form a single interrupt request. Software reads any register by number through a combinational move-from port. The status word can also be loaded through a move-to port.

Top module: `exc_state_regs`

## Requirements
- R1: After reset, every register (numbers 8, 12, 13, 14) reads as zero and `irq_req` is 0.
- R2: On `exc_take`, status bits 5:0 become the old bits 3:0 shifted up to 5:2, with bits 1:0 cleared (bit 1 = kernel/user flag, 0 means kernel; bit 0 = interrupt enable). Mask bits 15:8 are unchanged.
- R3: On `rfe` without `exc_take`, status bits 3:0 take the old bits 5:2, and bits 5:4 keep their value.
- R4: On `exc_take`, cause bits 5:2 capture `exc_code` for every one of the 16 code values.
- R5: On `exc_take`, the exception PC register (number 14) captures `exc_pc - 4`.
- R6: The faulting-address register (number 8) loads `exc_addr` on `exc_take` only when the code is 4 (address error on load or fetch) or 5 (address error on store). For any other code it holds its value.
- R7: Pending flag i (cause bit 10+i, i = 0..4) sets in the cycle after `irq_lines[i]` is high. It stays set until `irq_clr[i]` is pulsed. If set and clear arrive together, set wins.
- R8: `irq_req` is 1 exactly when some pending flag i has its mask bit (status bit 10+i) at 1 and status bit 0 is 1.
- R9: The read port returns status on number 12, cause on 13, exception PC on 14 and faulting address on 8. Every other number, and every undefined bit, reads 0.
- R10: In the same cycle as `exc_take`, `redirect_valid` is 1 and `redirect_pc` is 0x8000_0080. Otherwise `redirect_valid` is 0.
- R11: A move-to write (`mt_we`, `mt_sel` = 12) loads status with `mt_data` masked to bits 15:8 and 5:0. The write is ignored in a cycle that also has `exc_take` or `rfe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_take | input | 1 | Exception entry strobe |
| exc_code | input | 4 | Reason code for the exception |
| exc_pc | input | 32 | PC at entry (already advanced by 4) |
| exc_addr | input | 32 | Address of the faulting memory reference |
| rfe | input | 1 | Return-from-exception strobe |
| mt_we | input | 1 | Move-to write enable |
| mt_sel | input | 5 | Move-to register number |
| mt_data | input | 32 | Move-to write data |
| irq_lines | input | 5 | Hardware interrupt request lines |
| irq_clr | input | 5 | Per-level pending clear pulses |
| rd_sel | input | 5 | Move-from register number |
| rd_data | output | 32 | Move-from read data |
| redirect_valid | output | 1 | Handler redirect request |
| redirect_pc | output | 32 | Handler entry address |
| irq_req | output | 1 | Masked, enabled interrupt request |

## Verification
The redirect outputs are combinational on `exc_take`, so the bench samples them 1 ns after driving the strobe, before the clock edge. The bench drives every register update on a falling edge and reads the result back through the combinational read port after the next falling edge, which is one rising edge later. A pending flag and the `irq_req` it causes are due one rising edge after the interrupt line is driven, and they are sampled at that same point. The read port itself has no delay, so each register read is sampled 1 ns after `rd_sel` changes.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef logic [31:0] word_t;

  localparam logic [4:0] REG_BADADDR = 5'd8;
  localparam logic [4:0] REG_STATUS  = 5'd12;
  localparam logic [4:0] REG_CAUSE   = 5'd13;
  localparam logic [4:0] REG_EPC     = 5'd14;

  localparam logic [3:0] CODE_ADDR_LD = 4'd4;
  localparam logic [3:0] CODE_ADDR_ST = 4'd5;

  localparam word_t STATUS_WMASK = 32'h0000_FF3F;
  localparam word_t PC_STEP      = 32'd4;

  // push a kernel/disabled pair onto the three-level stack
  function automatic word_t status_on_entry(input word_t s);
    word_t r;
    r = s;
    r[5:0] = {s[3:0], 2'b00};
    return r;
  endfunction

  // pop one pair; the oldest pair stays where it is
  function automatic word_t status_on_return(input word_t s);
    word_t r;
    r = s;
    r[3:0] = s[5:2];
    return r;
  endfunction

  function automatic word_t epc_from_pc(input word_t pc);
    return pc - PC_STEP;
  endfunction

  function automatic logic code_records_addr(input logic [3:0] code);
    return (code == CODE_ADDR_LD) || (code == CODE_ADDR_ST);
  endfunction
endpackage

// File: rtl/exc_status_stack.sv
module exc_status_stack
  import exc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enter,
  input  logic  leave,
  input  logic  wr_en,
  input  word_t wr_data,
  output word_t status_q
);
  word_t status_d;

  always_comb begin
    status_d = status_q;
    if (enter)      status_d = status_on_entry(status_q);
    else if (leave) status_d = status_on_return(status_q);
    else if (wr_en) status_d = wr_data & STATUS_WMASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
  import exc_pkg::*;
#(
  parameter int HW_LEVELS = 5,
  parameter int PEND_LSB  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enter,
  input  logic [3:0]           code,
  input  logic [HW_LEVELS-1:0] irq_lines,
  input  logic [HW_LEVELS-1:0] irq_clr,
  output logic [HW_LEVELS-1:0] pend_q,
  output word_t                cause_q
);
  logic [3:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= '0;
    else if (enter) code_q <= code;
  end

  // one flag per level; a new request beats a clear in the same cycle
  for (genvar i = 0; i < HW_LEVELS; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n)            pend_q[i] <= 1'b0;
      else if (irq_lines[i]) pend_q[i] <= 1'b1;
      else if (irq_clr[i])   pend_q[i] <= 1'b0;
    end
  end

  always_comb begin
    cause_q = '0;
    cause_q[5:2] = code_q;
    cause_q[PEND_LSB +: HW_LEVELS] = pend_q;
  end
endmodule

// File: rtl/exc_addr_regs.sv
module exc_addr_regs
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter,
  input  logic [3:0] code,
  input  word_t      pc,
  input  word_t      fault_addr,
  output word_t      epc_q,
  output word_t      badaddr_q
);
  logic grab_addr;
  assign grab_addr = enter && code_records_addr(code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q     <= '0;
      badaddr_q <= '0;
    end else begin
      if (enter)     epc_q     <= epc_from_pc(pc);
      if (grab_addr) badaddr_q <= fault_addr;
    end
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int          HW_LEVELS  = 5,
  parameter int          PEND_LSB   = 10,
  parameter int          SEL_W      = 5,
  parameter logic [31:0] HANDLER_PC = 32'h8000_0080
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exc_take,
  input  logic [3:0]           exc_code,
  input  logic [31:0]          exc_pc,
  input  logic [31:0]          exc_addr,
  input  logic                 rfe,
  input  logic                 mt_we,
  input  logic [SEL_W-1:0]     mt_sel,
  input  logic [31:0]          mt_data,
  input  logic [HW_LEVELS-1:0] irq_lines,
  input  logic [HW_LEVELS-1:0] irq_clr,
  input  logic [SEL_W-1:0]     rd_sel,
  output logic [31:0]          rd_data,
  output logic                 redirect_valid,
  output logic [31:0]          redirect_pc,
  output logic                 irq_req
);
  // named internal events
  logic do_enter, do_leave, do_write;
  word_t status_q, cause_q, epc_q, badaddr_q;
  logic [HW_LEVELS-1:0] pend_q, mask_hw;

  assign do_enter = exc_take;
  assign do_leave = rfe && !exc_take;
  assign do_write = mt_we && (mt_sel == SEL_W'(REG_STATUS)) && !exc_take && !rfe;

  exc_status_stack u_status (
    .clk(clk), .rst_n(rst_n), .enter(do_enter), .leave(do_leave),
    .wr_en(do_write), .wr_data(mt_data), .status_q(status_q)
  );

  exc_cause_reg #(.HW_LEVELS(HW_LEVELS), .PEND_LSB(PEND_LSB)) u_cause (
    .clk(clk), .rst_n(rst_n), .enter(do_enter), .code(exc_code),
    .irq_lines(irq_lines), .irq_clr(irq_clr), .pend_q(pend_q), .cause_q(cause_q)
  );

  exc_addr_regs u_addr (
    .clk(clk), .rst_n(rst_n), .enter(do_enter), .code(exc_code),
    .pc(exc_pc), .fault_addr(exc_addr), .epc_q(epc_q), .badaddr_q(badaddr_q)
  );

  assign mask_hw = status_q[PEND_LSB +: HW_LEVELS];
  assign irq_req = (|(pend_q & mask_hw)) && status_q[0];

  assign redirect_valid = do_enter;
  assign redirect_pc    = do_enter ? HANDLER_PC : '0;

  always_comb begin
    unique case (rd_sel)
      SEL_W'(REG_BADADDR): rd_data = badaddr_q;
      SEL_W'(REG_STATUS):  rd_data = status_q;
      SEL_W'(REG_CAUSE):   rd_data = cause_q;
      SEL_W'(REG_EPC):     rd_data = epc_q;
      default:             rd_data = '0;
    endcase
  end
endmodule

// File: rtl/exc_state_regs_chk.sv
module exc_state_regs_chk #(
  parameter int          HW_LEVELS  = 5,
  parameter logic [31:0] HANDLER_PC = 32'h8000_0080
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 exc_take,
  input logic [3:0]           exc_code,
  input logic [31:0]          exc_pc,
  input logic                 rfe,
  input logic                 do_write,
  input logic [31:0]          mt_data,
  input logic [HW_LEVELS-1:0] irq_lines,
  input logic [HW_LEVELS-1:0] irq_clr,
  input logic [HW_LEVELS-1:0] pend_q,
  input logic [31:0]          status_q,
  input logic [31:0]          cause_q,
  input logic [31:0]          epc_q,
  input logic [31:0]          badaddr_q,
  input logic                 redirect_valid,
  input logic [31:0]          redirect_pc,
  input logic                 irq_req
);
  p_entry_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (status_q[5:0] == {$past(status_q[3:0]), 2'b00})
              && (status_q[15:8] == $past(status_q[15:8])));

  p_return_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !exc_take) |=> (status_q[3:0] == $past(status_q[5:2]))
                        && (status_q[5:4] == $past(status_q[5:4])));

  p_code_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> cause_q[5:2] == $past(exc_code));

  p_epc_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> epc_q == $past(exc_pc) - 32'd4);

  p_badaddr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_take && (exc_code == 4'd4 || exc_code == 4'd5)) |=> badaddr_q == $past(badaddr_q));

  p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & $past(irq_lines)) == $past(irq_lines));

  p_pend_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & ($past(pend_q) & ~$past(irq_clr))) == ($past(pend_q) & ~$past(irq_clr)));

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[0] || pend_q == '0) |-> !irq_req);

  p_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> redirect_valid && (redirect_pc == HANDLER_PC));

  p_no_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |-> !redirect_valid);

  p_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |=> status_q == ($past(mt_data) & 32'h0000_FF3F));

  p_cause_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q[1:0] == 2'b00) && (cause_q[9:6] == 4'd0) && (cause_q[31:16] == 16'd0));
endmodule

bind exc_state_regs exc_state_regs_chk #(.HW_LEVELS(HW_LEVELS), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .exc_code(exc_code), .exc_pc(exc_pc),
  .rfe(rfe), .do_write(do_write), .mt_data(mt_data), .irq_lines(irq_lines),
  .irq_clr(irq_clr), .pend_q(pend_q), .status_q(status_q), .cause_q(cause_q),
  .epc_q(epc_q), .badaddr_q(badaddr_q), .redirect_valid(redirect_valid),
  .redirect_pc(redirect_pc), .irq_req(irq_req)
);

// File: tb/exc_state_regs_bench.sv
`timescale 1ns/1ps
module exc_state_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_take = 1'b0;
  logic [3:0] exc_code = '0;
  logic [31:0] exc_pc = '0, exc_addr = '0, mt_data = '0;
  logic rfe = 1'b0, mt_we = 1'b0;
  logic [4:0] mt_sel = 5'd12, rd_sel = '0;
  logic [4:0] irq_lines = '0, irq_clr = '0;
  logic [31:0] rd_data, redirect_pc;
  logic redirect_valid, irq_req;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] m_status = 0, m_epc = 0, m_bad = 0, m_cause = 0;

  always #5 clk = ~clk;

  exc_state_regs u_exc_state_regs (
    .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_addr(exc_addr), .rfe(rfe), .mt_we(mt_we),
    .mt_sel(mt_sel), .mt_data(mt_data), .irq_lines(irq_lines), .irq_clr(irq_clr),
    .rd_sel(rd_sel), .rd_data(rd_data), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int sel, output logic [31:0] val);
    rd_sel = sel[4:0];
    #1;
    val = rd_data;
  endtask

  // bench model of the stack, in arithmetic form
  function automatic logic [31:0] m_enter(input logic [31:0] s);
    return (s & 32'hFFFF_FFC0) | (((s % 16) * 4) % 64);
  endfunction
  function automatic logic [31:0] m_leave(input logic [31:0] s);
    return (s & 32'hFFFF_FFF0) | ((s / 4) % 16);
  endfunction

  task automatic write_status(input logic [31:0] d);
    @(negedge clk); mt_we = 1; mt_sel = 5'd12; mt_data = d;
    @(negedge clk); mt_we = 0;
    m_status = d & 32'h0000_FF3F;
  endtask

  task automatic take_exc(input logic [3:0] code, input logic [31:0] pc, input logic [31:0] addr);
    @(negedge clk); exc_take = 1; exc_code = code; exc_pc = pc; exc_addr = addr;
    #1;
    check("R10 redirect_valid", {31'd0, redirect_valid}, 32'd1);
    check("R10 redirect_pc", redirect_pc, 32'h8000_0080);
    @(negedge clk); exc_take = 0;
    m_status = m_enter(m_status);
    m_epc = pc - 32'd4;
    if (code == 4 || code == 5) m_bad = addr;
    m_cause = (m_cause & 32'hFFFF_FFC3) | (32'(code) << 2);
  endtask

  task automatic do_rfe();
    @(negedge clk); rfe = 1;
    @(negedge clk); rfe = 0;
    m_status = m_leave(m_status);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8, v);  check("R1 badaddr reset", v, 0);
    rd(12, v); check("R1 status reset", v, 0);
    rd(13, v); check("R1 cause reset", v, 0);
    rd(14, v); check("R1 epc reset", v, 0);
    check("R1 irq_req reset", {31'd0, irq_req}, 0);
    #1; check("R10 no redirect idle", {31'd0, redirect_valid}, 0);

    // sweep every low-six-bit stack value and every code
    for (int k = 0; k < 64; k++) begin
      write_status(32'hFFFF_A500 | k);
      rd(12, v); check("R11 status write", v, m_status);
      take_exc(4'(k % 16), 32'h0040_0000 + k * 8, 32'h1000_0000 ^ k);
      rd(12, v); check("R2 entry shift", v, m_status);
      rd(13, v); check("R4 cause code", v, m_cause);
      rd(14, v); check("R5 epc", v, m_epc);
      rd(8, v);  check("R6 badaddr", v, m_bad);
      do_rfe();
      rd(12, v); check("R3 return pop", v, m_status);
    end

    // nested entries then returns
    write_status(32'h0000_3C03);
    for (int d = 0; d < 3; d++) begin
      take_exc(4'd12, 32'h0000_1000 + d * 4, 0);
      rd(12, v); check("R2 nested entry", v, m_status);
    end
    for (int d = 0; d < 3; d++) begin
      do_rfe();
      rd(12, v); check("R3 nested return", v, m_status);
    end

    // priority: write together with exception or return is ignored
    write_status(32'h0000_0015);
    @(negedge clk); mt_we = 1; mt_data = 32'h0000_FF3F; exc_take = 1; exc_code = 4'd8; exc_pc = 32'h200;
    @(negedge clk); mt_we = 0; exc_take = 0;
    m_status = m_enter(m_status); m_epc = 32'h1FC; m_cause = (m_cause & 32'hFFFF_FFC3) | (32'd8 << 2);
    rd(12, v); check("R11 write lost to exception", v, m_status);
    @(negedge clk); mt_we = 1; mt_data = 32'h0000_FF3F; rfe = 1;
    @(negedge clk); mt_we = 0; rfe = 0;
    m_status = m_leave(m_status);
    rd(12, v); check("R11 write lost to return", v, m_status);
    @(negedge clk); mt_we = 1; mt_sel = 5'd13; mt_data = 32'h0000_FF3F;
    @(negedge clk); mt_we = 0; mt_sel = 5'd12;
    rd(12, v); check("R11 write to other number ignored", v, m_status);

    // pending flags and request
    write_status(32'h0000_7C01);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); irq_lines = 5'(1 << i);
      @(negedge clk); irq_lines = 0;
      m_cause = m_cause | (32'd1 << (10 + i));
      #1; check("R8 request on", {31'd0, irq_req}, 1);
      @(negedge clk);
      rd(13, v); check("R7 pending held", v, m_cause);
      irq_clr = 5'(1 << i);
      @(negedge clk); irq_clr = 0;
      m_cause = m_cause & ~(32'd1 << (10 + i));
      rd(13, v); check("R7 pending cleared", v, m_cause);
      #1; check("R8 request off", {31'd0, irq_req}, 0);
    end
    @(negedge clk); irq_lines = 5'b00100; irq_clr = 5'b00100;
    @(negedge clk); irq_lines = 0; irq_clr = 0;
    m_cause = m_cause | (32'd1 << 12);
    rd(13, v); check("R7 set beats clear", v, m_cause);
    write_status(32'h0000_6C01);
    #1; check("R8 masked level", {31'd0, irq_req}, 0);
    write_status(32'h0000_7C00);
    #1; check("R8 disabled", {31'd0, irq_req}, 0);
    write_status(32'h0000_7C01);
    #1; check("R8 re-enabled", {31'd0, irq_req}, 1);

    // read map sweep
    for (int s = 0; s < 32; s++) begin
      logic [31:0] e;
      case (s)
        8: e = m_bad; 12: e = m_status; 13: e = m_cause; 14: e = m_epc;
        default: e = 0;
      endcase
      rd(s, v); check("R9 read map", v, e);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule